// File: doc/BRIEF.md
# Processor Core Fault Capture Unit

This block sits next to a processor core and collects the detection strobes from the core's protected structures. These are the single-bit and double-bit upset flags of the program counter, the instruction register and the register file, plus the mismatch flags of the triplicated control and ALU logic. One further strobe comes from outside the core, so that logic at system level has its own way to report faults. Any strobe sets a bit in a sticky error-identifier register. While that register is nonzero, the block holds a trap request toward the core's trap controller, whether or not the fault could be corrected.

On the first error after software has acknowledged everything, the block freezes a snapshot of the processor state: ALU result, PC, IR, the 64-bit cycle count and, for upset errors, the corrupted codeword together with its check bits. Software reads these over a small word-addressed register bus. It clears identifier bits by writing ones to them, and the trap request drops once no bit remains set. Beside this, an eight-entry ring of call-site PCs follows call and return pulses, so that a handler can rebuild the calling chain in which the fault hit.

Top module: `core_fault_handler`

## Requirements
- R1: Each strobe bit `err_i[k]` sets identifier bit k on the next clock edge. The bit positions are: 0 PC single, 1 PC double, 2 IR single, 3 IR double, 4 register-file single, 5 register-file double, 6 control mismatch, 7 ALU mismatch, 8 external. Reading word address 0 returns the identifier in bits 8:0.
- R2: `trap_o` is high exactly when the identifier register is nonzero, so it rises one cycle after the first strobe, with no regard to correctability.
- R3: On a strobe that finds the identifier empty (after that cycle's clear is applied), the unit stores `alu_i`, `pc_i`, `ir_i` and `cycle_i` from that same cycle. Read addresses: 1 ALU, 2 PC, 3 IR, 4 cycle bits 31:0, 5 cycle bits 63:32.
- R4: In that same capture, the codeword register takes `pc_cw_i` if bit 0 or 1 fires, otherwise `ir_cw_i` if bit 2 or 3 fires, otherwise `rf_cw_i` if bit 4 or 5 fires, and otherwise zero. Address 6 reads the 32 data bits [31:0]; address 7 reads the 7 check bits [38:32], zero-extended.
- R5: Strobes that arrive while the identifier stays nonzero are OR-ed into it but leave every snapshot register unchanged.
- R6: A write to address 0 clears each identifier bit whose write-data bit is one. If a strobe falls in the same cycle, its bits remain set. If the clear empties the register in that cycle, the snapshot is taken from that cycle.
- R7: Writes to any address other than 0 change no readable register.
- R8: A call pulse without a return stores `pc_i` into ring entry `ptr` and advances `ptr` by one, modulo 8. Address 8 reads `ptr`; addresses 16 to 23 read ring entries 0 to 7.
- R9: A return pulse without a call clears entry `ptr-1` and moves `ptr` back by one, modulo 8. Call and return together overwrite entry `ptr-1` with `pc_i` and leave `ptr` unchanged.
- R10: After reset, every readable register is zero and `trap_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| err_i | input | 9 | Error detection strobes, one per error type |
| alu_i | input | 32 | Current ALU result |
| pc_i | input | 32 | Current program counter |
| ir_i | input | 32 | Current instruction register |
| cycle_i | input | 64 | Running cycle count |
| pc_cw_i | input | 39 | PC codeword as received (check bits on top) |
| ir_cw_i | input | 39 | IR codeword as received |
| rf_cw_i | input | 39 | Register-file codeword as received |
| call_i | input | 1 | Function-call pulse |
| ret_i | input | 1 | Function-return pulse |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 5 | Register word address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data, combinational on address |
| trap_o | output | 1 | Trap request |

## Verification
Two pairs of events can fall in the same cycle. The first is a software acknowledge of the identifier and a fresh strobe. The second is a call pulse and a return pulse. The directed part of the bench forces both: an acknowledge of all bits together with a new strobe, an acknowledge of only some bits together with a new strobe, and a call paired with a return. The random phase then lets strobes, acknowledges, calls and returns coincide freely. After every cycle a bench model, written from the requirements, gives the identifier, snapshot, pointer and ring contents, and the bench compares them against all readable addresses. A mismatch shows whether a fresh snapshot was taken wrongly or withheld wrongly, and whether the ring pointer moved when it should not have.

// File: rtl/cfh_pkg.sv
package cfh_pkg;
  localparam int NUM_ERR = 9;
  // error identifier bit positions
  localparam int E_PC_S   = 0;
  localparam int E_PC_D   = 1;
  localparam int E_IR_S   = 2;
  localparam int E_IR_D   = 3;
  localparam int E_RF_S   = 4;
  localparam int E_RF_D   = 5;
  localparam int E_CTL    = 6;
  localparam int E_ALU    = 7;
  localparam int E_EXT    = 8;

  // register word addresses
  localparam logic [4:0] A_ID     = 5'd0;
  localparam logic [4:0] A_ALU    = 5'd1;
  localparam logic [4:0] A_PC     = 5'd2;
  localparam logic [4:0] A_IR     = 5'd3;
  localparam logic [4:0] A_CYC_LO = 5'd4;
  localparam logic [4:0] A_CYC_HI = 5'd5;
  localparam logic [4:0] A_CW_DAT = 5'd6;
  localparam logic [4:0] A_CW_CHK = 5'd7;
  localparam logic [4:0] A_QPTR   = 5'd8;
  localparam logic [4:0] A_QBASE  = 5'd16;

  typedef logic [NUM_ERR-1:0] err_vec_t;

  // identifier after this cycle's write-one-to-clear, before new strobes
  function automatic err_vec_t id_after_ack(err_vec_t id, err_vec_t clr);
    return id & ~clr;
  endfunction
endpackage

// File: rtl/cfh_err_capture.sv
module cfh_err_capture
  import cfh_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int CHK_W = 7,
  parameter int CYC_W = 64
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  err_vec_t              err_i,
  input  err_vec_t              clr_i,
  input  logic [XLEN-1:0]       alu_i,
  input  logic [XLEN-1:0]       pc_i,
  input  logic [XLEN-1:0]       ir_i,
  input  logic [CYC_W-1:0]      cycle_i,
  input  logic [XLEN+CHK_W-1:0] pc_cw_i,
  input  logic [XLEN+CHK_W-1:0] ir_cw_i,
  input  logic [XLEN+CHK_W-1:0] rf_cw_i,
  output err_vec_t              id_o,
  output logic                  load_o,
  output logic [XLEN-1:0]       snap_alu_o,
  output logic [XLEN-1:0]       snap_pc_o,
  output logic [XLEN-1:0]       snap_ir_o,
  output logic [CYC_W-1:0]      snap_cyc_o,
  output logic [XLEN+CHK_W-1:0] snap_cw_o
);
  localparam int CW_W = XLEN + CHK_W;

  function automatic logic [CW_W-1:0] pick_cw(err_vec_t e, logic [CW_W-1:0] pcw,
                                              logic [CW_W-1:0] icw, logic [CW_W-1:0] rcw);
    if (e[E_PC_S] | e[E_PC_D])      return pcw;
    else if (e[E_IR_S] | e[E_IR_D]) return icw;
    else if (e[E_RF_S] | e[E_RF_D]) return rcw;
    else                            return '0;
  endfunction

  err_vec_t id_q, id_acked;
  logic     any_err;

  assign any_err  = |err_i;
  assign id_acked = id_after_ack(id_q, clr_i);
  assign load_o   = any_err && (id_acked == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) id_q <= '0;
    else         id_q <= id_acked | err_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_alu_o <= '0;
      snap_pc_o  <= '0;
      snap_ir_o  <= '0;
      snap_cyc_o <= '0;
      snap_cw_o  <= '0;
    end else if (load_o) begin
      snap_alu_o <= alu_i;
      snap_pc_o  <= pc_i;
      snap_ir_o  <= ir_i;
      snap_cyc_o <= cycle_i;
      snap_cw_o  <= pick_cw(err_i, pc_cw_i, ir_cw_i, rf_cw_i);
    end
  end

  assign id_o = id_q;
endmodule

// File: rtl/cfh_call_ring.sv
module cfh_call_ring #(
  parameter int XLEN  = 32,
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       call_i,
  input  logic                       ret_i,
  input  logic [XLEN-1:0]            pc_i,
  output logic [PTR_W-1:0]           ptr_o,
  output logic [DEPTH-1:0][XLEN-1:0] ent_o
);
  function automatic logic [PTR_W-1:0] ring_step(logic [PTR_W-1:0] p, logic up);
    return up ? p + PTR_W'(1) : p - PTR_W'(1);
  endfunction

  logic [PTR_W-1:0] ptr_q, top_idx, wr_idx;
  logic             push_only, pop_only, swap, wr_en;
  logic [XLEN-1:0]  wr_val;

  assign push_only = call_i && !ret_i;
  assign pop_only  = ret_i && !call_i;
  assign swap      = call_i && ret_i;
  assign top_idx   = ring_step(ptr_q, 1'b0);
  assign wr_en     = call_i || ret_i;
  assign wr_idx    = push_only ? ptr_q : top_idx;
  assign wr_val    = pop_only ? '0 : pc_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ptr_q <= '0;
    else if (push_only) ptr_q <= ring_step(ptr_q, 1'b1);
    else if (pop_only)  ptr_q <= top_idx;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [XLEN-1:0] ent_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             ent_q <= '0;
      else if (wr_en && wr_idx == PTR_W'(g))   ent_q <= wr_val;
    end
    assign ent_o[g] = ent_q;
  end

  logic unused_swap;
  assign unused_swap = swap;
  assign ptr_o = ptr_q;
endmodule

// File: rtl/cfh_read_mux.sv
module cfh_read_mux
  import cfh_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CHK_W  = 7,
  parameter int CYC_W  = 64,
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 5,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic [ADDR_W-1:0]          addr_i,
  input  err_vec_t                   id_i,
  input  logic [XLEN-1:0]            alu_i,
  input  logic [XLEN-1:0]            pc_i,
  input  logic [XLEN-1:0]            ir_i,
  input  logic [CYC_W-1:0]           cyc_i,
  input  logic [XLEN+CHK_W-1:0]      cw_i,
  input  logic [PTR_W-1:0]           ptr_i,
  input  logic [DEPTH-1:0][XLEN-1:0] ent_i,
  output logic [XLEN-1:0]            rdata_o
);
  logic [ADDR_W-1:0] q_off;
  logic              in_ring;

  assign q_off   = addr_i - ADDR_W'(A_QBASE);
  assign in_ring = (addr_i >= ADDR_W'(A_QBASE)) && (q_off < ADDR_W'(DEPTH));

  always_comb begin
    rdata_o = '0;
    if (in_ring) begin
      rdata_o = ent_i[q_off[PTR_W-1:0]];
    end else begin
      case (addr_i)
        ADDR_W'(A_ID):     rdata_o = XLEN'(id_i);
        ADDR_W'(A_ALU):    rdata_o = alu_i;
        ADDR_W'(A_PC):     rdata_o = pc_i;
        ADDR_W'(A_IR):     rdata_o = ir_i;
        ADDR_W'(A_CYC_LO): rdata_o = cyc_i[XLEN-1:0];
        ADDR_W'(A_CYC_HI): rdata_o = cyc_i[CYC_W-1:XLEN];
        ADDR_W'(A_CW_DAT): rdata_o = cw_i[XLEN-1:0];
        ADDR_W'(A_CW_CHK): rdata_o = XLEN'(cw_i[XLEN+CHK_W-1:XLEN]);
        ADDR_W'(A_QPTR):   rdata_o = XLEN'(ptr_i);
        default:           rdata_o = '0;
      endcase
    end
  end

  logic unused_off_hi;
  assign unused_off_hi = ^q_off[ADDR_W-1:PTR_W];
endmodule

// File: rtl/core_fault_handler.sv
module core_fault_handler
  import cfh_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CHK_W  = 7,
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 5,
  localparam int CYC_W = 2 * XLEN,
  localparam int CW_W  = XLEN + CHK_W,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_ERR-1:0]  err_i,
  input  logic [XLEN-1:0]     alu_i,
  input  logic [XLEN-1:0]     pc_i,
  input  logic [XLEN-1:0]     ir_i,
  input  logic [CYC_W-1:0]    cycle_i,
  input  logic [CW_W-1:0]     pc_cw_i,
  input  logic [CW_W-1:0]     ir_cw_i,
  input  logic [CW_W-1:0]     rf_cw_i,
  input  logic                call_i,
  input  logic                ret_i,
  input  logic                bus_we_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [XLEN-1:0]     bus_wdata_i,
  output logic [XLEN-1:0]     bus_rdata_o,
  output logic                trap_o
);
  err_vec_t                   id, ack_mask;
  logic                       snap_load, id_write;
  logic [XLEN-1:0]            snap_alu, snap_pc, snap_ir;
  logic [CYC_W-1:0]           snap_cyc;
  logic [CW_W-1:0]            snap_cw;
  logic [PTR_W-1:0]           ring_ptr;
  logic [DEPTH-1:0][XLEN-1:0] ring_ent;
  logic                       trap_q;

  assign id_write = bus_we_i && (bus_addr_i == ADDR_W'(A_ID));
  assign ack_mask = id_write ? bus_wdata_i[NUM_ERR-1:0] : '0;

  cfh_err_capture #(.XLEN(XLEN), .CHK_W(CHK_W), .CYC_W(CYC_W)) u_cap (
    .clk_i, .rst_ni, .err_i, .clr_i(ack_mask),
    .alu_i, .pc_i, .ir_i, .cycle_i, .pc_cw_i, .ir_cw_i, .rf_cw_i,
    .id_o(id), .load_o(snap_load),
    .snap_alu_o(snap_alu), .snap_pc_o(snap_pc), .snap_ir_o(snap_ir),
    .snap_cyc_o(snap_cyc), .snap_cw_o(snap_cw)
  );

  cfh_call_ring #(.XLEN(XLEN), .DEPTH(DEPTH)) u_ring (
    .clk_i, .rst_ni, .call_i, .ret_i, .pc_i,
    .ptr_o(ring_ptr), .ent_o(ring_ent)
  );

  cfh_read_mux #(.XLEN(XLEN), .CHK_W(CHK_W), .CYC_W(CYC_W), .DEPTH(DEPTH),
                 .ADDR_W(ADDR_W)) u_rd (
    .addr_i(bus_addr_i), .id_i(id), .alu_i(snap_alu), .pc_i(snap_pc),
    .ir_i(snap_ir), .cyc_i(snap_cyc), .cw_i(snap_cw), .ptr_i(ring_ptr),
    .ent_i(ring_ent), .rdata_o(bus_rdata_o)
  );

  // trap request registered from the next-state of the identifier
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trap_q <= 1'b0;
    else         trap_q <= |(id_after_ack(id, ack_mask) | err_i);
  end
  assign trap_o = trap_q;

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^bus_wdata_i[XLEN-1:NUM_ERR];
endmodule

// File: rtl/core_fault_handler_chk.sv
module core_fault_handler_chk #(
  parameter int XLEN = 32,
  parameter int NERR = 9,
  parameter int PW   = 3,
  parameter int AW   = 5
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [NERR-1:0] err_i,
  input logic            trap_o,
  input logic            bus_we_i,
  input logic [AW-1:0]   bus_addr_i,
  input logic [XLEN-1:0] bus_wdata_i,
  input logic            call_i,
  input logic            ret_i,
  input logic [NERR-1:0] id,
  input logic [PW-1:0]   ring_ptr,
  input logic [XLEN-1:0] snap_pc,
  input logic [XLEN-1:0] snap_alu
);
  logic id_wr;
  assign id_wr = bus_we_i && (bus_addr_i == '0);

  assert_strobe_sets_id_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|err_i) |=> ((id & $past(err_i)) == $past(err_i)));

  assert_trap_after_error_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|err_i) |=> trap_o);

  assert_trap_matches_id_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o == (id != '0));

  assert_snapshot_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_o && !id_wr) |=> ($stable(snap_pc) && $stable(snap_alu)));

  assert_ack_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_wr && !(|err_i)) |=> ((id & $past(bus_wdata_i[NERR-1:0])) == '0));

  assert_call_advances_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_i && !ret_i) |=> (ring_ptr == PW'($past(ring_ptr) + 1'b1)));

  assert_return_retreats_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !call_i) |=> (ring_ptr == PW'($past(ring_ptr) - 1'b1)));

  assert_pair_keeps_ptr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && call_i) |=> $stable(ring_ptr));
endmodule

bind core_fault_handler core_fault_handler_chk #(
  .XLEN(XLEN), .NERR(cfh_pkg::NUM_ERR), .PW(PTR_W), .AW(ADDR_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .err_i(err_i), .trap_o(trap_o),
  .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
  .call_i(call_i), .ret_i(ret_i), .id(id), .ring_ptr(ring_ptr),
  .snap_pc(snap_pc), .snap_alu(snap_alu)
);

// File: tb/tb_core_fault_handler.sv
`timescale 1ns/1ps
module tb_core_fault_handler;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [8:0]  err = '0;
  logic [31:0] alu = '0, pc = '0, ir = '0, wdata = '0;
  logic [63:0] cyc = '0;
  logic [38:0] pcw = '0, icw = '0, rcw = '0;
  logic        call = 1'b0, ret = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] rdata;
  logic        trap;

  core_fault_handler dut (
    .clk_i(clk), .rst_ni(rst_n), .err_i(err), .alu_i(alu), .pc_i(pc), .ir_i(ir),
    .cycle_i(cyc), .pc_cw_i(pcw), .ir_cw_i(icw), .rf_cw_i(rcw),
    .call_i(call), .ret_i(ret), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .trap_o(trap)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench model
  logic [8:0]  m_id;
  logic [31:0] m_alu, m_pc, m_ir;
  logic [63:0] m_cyc;
  logic [38:0] m_cw;
  logic [2:0]  m_ptr;
  logic [31:0] m_q [8];

  task automatic model_reset();
    m_id = '0; m_alu = '0; m_pc = '0; m_ir = '0; m_cyc = '0; m_cw = '0; m_ptr = '0;
    for (int i = 0; i < 8; i++) m_q[i] = '0;
  endtask

  function automatic logic [38:0] exp_cw(logic [8:0] e);
    if (e[1:0] != 0) return pcw;
    if (e[3:2] != 0) return icw;
    if (e[5:4] != 0) return rcw;
    return '0;
  endfunction

  function automatic logic [31:0] exp_reg(logic [4:0] a);
    if (a >= 16 && a < 24) return m_q[a - 16];
    case (a)
      0: return {23'd0, m_id};
      1: return m_alu;
      2: return m_pc;
      3: return m_ir;
      4: return m_cyc[31:0];
      5: return m_cyc[63:32];
      6: return m_cw[31:0];
      7: return {25'd0, m_cw[38:32]};
      8: return {29'd0, m_ptr};
      default: return '0;
    endcase
  endfunction

  task automatic model_step();
    logic [8:0] left;
    logic [2:0] top;
    left = m_id & ~((we && addr == 0) ? wdata[8:0] : 9'd0);
    if (left == 0 && err != 0) begin
      m_alu = alu; m_pc = pc; m_ir = ir; m_cyc = cyc; m_cw = exp_cw(err);
    end
    m_id = left | err;
    top = m_ptr - 3'd1;
    if (call && ret) m_q[top] = pc;
    else if (call) begin m_q[m_ptr] = pc; m_ptr = m_ptr + 3'd1; end
    else if (ret) begin m_q[top] = '0; m_ptr = top; end
  endtask

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic check_all(string req);
    chk(req, "trap", {31'd0, trap}, {31'd0, m_id != 0});
    for (int a = 0; a < 24; a++) begin
      addr = 5'(a);
      #0.1;
      chk(req, $sformatf("reg %0d", a), rdata, exp_reg(5'(a)));
    end
  endtask

  // one clock: apply at negedge, model after posedge, release at next negedge
  task automatic tick(logic [8:0] e, logic w, logic [4:0] a, logic [31:0] d,
                      logic c, logic r);
    @(negedge clk);
    err = e; we = w; addr = a; wdata = d; call = c; ret = r;
    alu = $urandom; pc = $urandom; ir = $urandom; cyc = {$urandom, $urandom};
    pcw = {7'($urandom), 32'($urandom)};
    icw = {7'($urandom), 32'($urandom)};
    rcw = {7'($urandom), 32'($urandom)};
    @(posedge clk);
    model_step();
    @(negedge clk);
    err = '0; we = 1'b0; call = 1'b0; ret = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R10");

    // R1/R3/R4: each strobe type alone, then acknowledge
    for (int k = 0; k < 9; k++) begin
      tick(9'(1 << k), 0, 0, 0, 0, 0);
      check_all(k < 6 ? "R4" : "R1");
      tick(0, 1, 0, 32'h1ff, 0, 0);
      check_all("R6");
    end

    // R3: several upset types at once, priority PC over IR over RF
    tick(9'b000111100, 0, 0, 0, 0, 0);
    check_all("R3");
    // R5: more strobes while pending keep the snapshot
    tick(9'b100000011, 0, 0, 0, 0, 0);
    check_all("R5");
    // R7: writes to read-only addresses
    tick(0, 1, 5'd2, 32'hdeadbeef, 0, 0);
    tick(0, 1, 5'd8, 32'h5, 0, 0);
    tick(0, 1, 5'd17, 32'h12345678, 0, 0);
    check_all("R7");
    // R6: partial ack with a new strobe: no new snapshot
    tick(9'b001000000, 1, 0, 32'h003, 0, 0);
    check_all("R6");
    // R6: full ack with a new strobe in the same cycle: fresh snapshot
    tick(9'b000010000, 1, 0, 32'h1ff, 0, 0);
    check_all("R6");
    chk("R2", "trap held", {31'd0, trap}, 32'd1);
    tick(0, 1, 0, 32'h1ff, 0, 0);
    check_all("R2");

    // R8: nine calls wrap the ring
    for (int i = 0; i < 9; i++) tick(0, 0, 0, 0, 1, 0);
    check_all("R8");
    // R9: returns, pairs, and wrap below zero
    tick(0, 0, 0, 0, 1, 1);
    check_all("R9");
    for (int i = 0; i < 3; i++) tick(0, 0, 0, 0, 0, 1);
    check_all("R9");

    // random phase: all functions may coincide
    for (int it = 0; it < 600; it++) begin
      logic [8:0] e;
      logic w;
      logic [4:0] a;
      e = ($urandom % 4 == 0) ? 9'($urandom) : 9'd0;
      w = ($urandom % 3 == 0);
      a = ($urandom % 4 == 0) ? 5'($urandom) : 5'd0;
      tick(e, w, a, $urandom, ($urandom % 3 == 0), ($urandom % 4 == 0));
      check_all("R5");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule